// File: doc/BRIEF.md
# Tree-Reduced 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns the 8-bit product in the same cycle, with no registers on the path. A grid of two-input AND gates forms all sixteen partial-product bits at once. A carry-save tree of full and half adders then cuts the columns down to two rows, and a ripple carry-propagate adder turns those two rows into the binary result.

A parameter picks one of two reduction schedules. The early schedule places an adder in every column that can take one, at every stage. This leaves a narrow final adder. The late schedule keeps the same number of stages but adds in a column only when that column would otherwise be too tall for the next stage. It uses fewer cells and leaves a wider final adder. Both schedules give the same product for every input pair, so the choice trades cell count against final-adder width.

Top module: `mul_tree_top`

## Requirements
- R1: With the early (Wallace) schedule selected (STYLE = 0), `product` equals `opnd_a * opnd_b` for all 256 operand pairs.
- R2: With the late (Dadda) schedule selected (STYLE = 1), `product` equals `opnd_a * opnd_b` for all 256 operand pairs.
- R3: For every operand pair, two instances that differ only in STYLE give identical products.
- R4: If either operand is 0, the product is 0.
- R5: 15 x 15 gives 225 (8'hE1). Bit 7 of the product comes from the carry out of the final adder.
- R6: The early schedule uses 5 full adders and 3 half adders in two stages. Its second carry-save row is zero in columns 0 to 2, so the final adder spans columns 3 to 6 (4 bits), and product bits 2:0 come straight from the tree.
- R7: The late schedule uses 4 full adders and 2 half adders in two stages. Its second carry-save row is zero in column 0, so the final adder spans columns 1 to 6 (6 bits).
- R8: The two carry-save rows (columns 0 to 6) always add up to `opnd_a * opnd_b`. This holds for operand pairs that make the longest carry chains in the final adder.
- R9: When each operand has exactly one bit set (1, 2, 4 or 8), the product is the single bit at position i+j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | Multiplicand, unsigned |
| opnd_b | input | 4 | Multiplier, unsigned |
| product | output | 8 | Unsigned product, combinational |

## Verification
Both schedules are run over all 256 operand pairs and compared with the arithmetic product and with each other. This finds any wrong wire in either tree, including one that only one schedule uses. Zero operands and one-hot operands come next. They tell a wrong column weight apart from a broken adder cell, because a one-hot pair puts a single bit in one known column. Large operands such as 15 x 15 and 13 x 11 run the carry through the whole final adder and into bit 7. This separates a wrong window edge or a lost carry out from an error inside the tree.

// File: rtl/mul_tree_pkg.sv
package mul_tree_pkg;

    localparam int OP_W   = 4;
    localparam int PROD_W = 2 * OP_W;
    localparam int ROW_W  = PROD_W - 1;   // carry-save rows span columns 0..PROD_W-2

    typedef enum logic [0:0] {
        STYLE_WALLACE = 1'b0,
        STYLE_DADDA   = 1'b1
    } tree_style_e;

    typedef logic [OP_W-1:0]   operand_t;
    typedef logic [PROD_W-1:0] product_t;
    typedef logic [ROW_W-1:0]  csrow_t;

    // pp[i][j] = a[i] & b[j], weight i+j
    typedef logic [OP_W-1:0][OP_W-1:0] pp_matrix_t;

    typedef struct packed {
        csrow_t row_x;
        csrow_t row_y;
    } cs_pair_t;

    // Lowest column the final adder must cover for each schedule.
    function automatic int cpa_lo(tree_style_e s);
        return (s == STYLE_WALLACE) ? 3 : 1;
    endfunction

    // Columns in which the second row may carry a bit.
    function automatic csrow_t window_mask(tree_style_e s);
        csrow_t m;
        for (int i = 0; i < ROW_W; i++) begin
            m[i] = (i >= cpa_lo(s));
        end
        return m;
    endfunction

endpackage

// File: rtl/mt_fa.sv
module mt_fa (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/mt_ha.sv
module mt_ha (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    assign s = x ^ y;
    assign c = x & y;
endmodule

// File: rtl/mt_pp_gen.sv
module mt_pp_gen
    import mul_tree_pkg::*;
(
    input  operand_t   a,
    input  operand_t   b,
    output pp_matrix_t pp
);
    for (genvar i = 0; i < OP_W; i++) begin : g_row
        for (genvar j = 0; j < OP_W; j++) begin : g_col
            assign pp[i][j] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/mt_reduce.sv
module mt_reduce
    import mul_tree_pkg::*;
#(
    parameter tree_style_e STYLE = STYLE_WALLACE
) (
    input  pp_matrix_t pp,
    output cs_pair_t   rows
);
    if (STYLE == STYLE_WALLACE) begin : g_wallace
        // Stage 1: rows 0..2 reduced wherever possible (2 FA, 2 HA)
        logic s1a, c1a, s2a, c2a, s3a, c3a, s4a, c4a;
        mt_ha u_h1a (.x(pp[0][1]), .y(pp[1][0]), .s(s1a), .c(c1a));
        mt_fa u_f2a (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(s2a), .c(c2a));
        mt_fa u_f3a (.x(pp[0][3]), .y(pp[1][2]), .z(pp[2][1]), .s(s3a), .c(c3a));
        mt_ha u_h4a (.x(pp[1][3]), .y(pp[2][2]), .s(s4a), .c(c4a));

        // Stage 2: every column of height two or more reduced (3 FA, 1 HA)
        logic s2b, c2b, s3b, c3b, s4b, c4b, s5b, c5b;
        mt_ha u_h2b (.x(s2a), .y(c1a), .s(s2b), .c(c2b));
        mt_fa u_f3b (.x(s3a), .y(c2a), .z(pp[3][0]), .s(s3b), .c(c3b));
        mt_fa u_f4b (.x(s4a), .y(c3a), .z(pp[3][1]), .s(s4b), .c(c4b));
        mt_fa u_f5b (.x(pp[2][3]), .y(c4a), .z(pp[3][2]), .s(s5b), .c(c5b));

        assign rows.row_x = {pp[3][3], s5b, s4b, s3b, s2b, s1a, pp[0][0]};
        assign rows.row_y = {c5b, c4b, c3b, c2b, 3'b000};
    end else begin : g_dadda
        // Stage 1: bring max height to 3, only where needed (2 HA)
        logic d3s, d3c, d4s, d4c;
        mt_ha u_h3 (.x(pp[0][3]), .y(pp[1][2]), .s(d3s), .c(d3c));
        mt_ha u_h4 (.x(pp[1][3]), .y(pp[2][2]), .s(d4s), .c(d4c));

        // Stage 2: bring max height to 2 (4 FA)
        logic e2s, e2c, e3s, e3c, e4s, e4c, e5s, e5c;
        mt_fa u_f2 (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(e2s), .c(e2c));
        mt_fa u_f3 (.x(pp[2][1]), .y(pp[3][0]), .z(d3s), .s(e3s), .c(e3c));
        mt_fa u_f4 (.x(pp[3][1]), .y(d3c), .z(d4s), .s(e4s), .c(e4c));
        mt_fa u_f5 (.x(pp[2][3]), .y(pp[3][2]), .z(d4c), .s(e5s), .c(e5c));

        assign rows.row_x = {pp[3][3], e5s, e4s, e3s, e2s, pp[0][1], pp[0][0]};
        assign rows.row_y = {e5c, e4c, e3c, e2c, 1'b0, pp[1][0], 1'b0};
    end
endmodule

// File: rtl/mt_cpa.sv
module mt_cpa
    import mul_tree_pkg::*;
#(
    parameter int LO = 1
) (
    input  cs_pair_t rows,
    output product_t sum
);
    localparam int WIDTH = ROW_W - LO;   // bits LO..ROW_W-1

    logic [WIDTH:0] carry;
    assign carry[0] = 1'b0;

    // Below the window the second row is empty, so a plain OR merges the rows.
    assign sum[LO-1:0] = rows.row_x[LO-1:0] | rows.row_y[LO-1:0];

    for (genvar k = 0; k < WIDTH; k++) begin : g_ripple
        mt_fa u_fa (
            .x(rows.row_x[LO+k]),
            .y(rows.row_y[LO+k]),
            .z(carry[k]),
            .s(sum[LO+k]),
            .c(carry[k+1])
        );
    end

    assign sum[PROD_W-1] = carry[WIDTH];
endmodule

// File: rtl/mul_tree_top.sv
module mul_tree_top
    import mul_tree_pkg::*;
#(
    parameter tree_style_e STYLE = STYLE_WALLACE
) (
    input  logic [3:0] opnd_a,
    input  logic [3:0] opnd_b,
    output logic [7:0] product
);
    localparam int     LO_COL = cpa_lo(STYLE);
    localparam csrow_t WINDOW = window_mask(STYLE);

    pp_matrix_t pp;
    cs_pair_t   rows;

    mt_pp_gen u_pp (.a(opnd_a), .b(opnd_b), .pp(pp));

    mt_reduce #(.STYLE(STYLE)) u_tree (.pp(pp), .rows(rows));

    mt_cpa #(.LO(LO_COL)) u_cpa (.rows(rows), .sum(product));

    always_comb begin
        // R1 R2
        prod_match_chk: assert (product == product_t'(opnd_a) * product_t'(opnd_b));
        // R8
        cs_sum_chk: assert ((product_t'(rows.row_x) + product_t'(rows.row_y))
                            == product_t'(opnd_a) * product_t'(opnd_b));
        // R6 R7
        window_chk: assert ((rows.row_y & ~WINDOW) == '0);
        // R4
        zero_op_chk: assert (!((opnd_a == '0) || (opnd_b == '0)) || (product == '0));
        // R5
        top_bit_chk: assert (!product[PROD_W-1] || (rows.row_x[ROW_W-1] | rows.row_y[ROW_W-1]));
    end
endmodule

// File: tb/mul_tree_top_bench.sv
module mul_tree_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a = '0;
    logic [3:0] b = '0;
    logic [7:0] p_w, p_d;
    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mul_tree_top #(.STYLE(mul_tree_pkg::STYLE_WALLACE)) u_mul_tree_top (
        .opnd_a(a), .opnd_b(b), .product(p_w));
    mul_tree_top #(.STYLE(mul_tree_pkg::STYLE_DADDA)) u_mul_tree_top_dadda (
        .opnd_a(a), .opnd_b(b), .product(p_d));

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d got=%0d expected=%0d", req, a, b, got, exp);
        end
    endtask

    // Drive on the falling edge, sample shortly after the next rising edge.
    task automatic apply(input int x, input int y);
        @(negedge clk);
        a = 4'(x);
        b = 4'(y);
        @(posedge clk);
        #2;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ref_q[$];
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        // R4 reset state: zero operands give zero product
        check("R4 reset wallace", p_w, 0);
        check("R4 reset dadda", p_d, 0);

        // Reference model: queue of expected products, popped per applied pair
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                ref_q.push_back(x * y);
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                int exp;
                apply(x, y);
                exp = ref_q.pop_front();
                check("R1 wallace product", p_w, exp);
                check("R2 dadda product", p_d, exp);
                check("R3 styles agree", p_w, p_d);
            end
        end

        for (int k = 0; k < 16; k++) begin
            apply(0, k);
            check("R4 zero a", p_w, 0);
            check("R4 zero a dadda", p_d, 0);
            apply(k, 0);
            check("R4 zero b", p_w, 0);
            check("R4 zero b dadda", p_d, 0);
        end

        apply(15, 15);
        check("R5 max wallace", p_w, 225);
        check("R5 max dadda", p_d, 225);
        check("R5 bit7 set", int'(p_w[7]), 1);

        // R6: low bits 2:0 come straight from the tree
        for (int x = 0; x < 16; x += 3) begin
            apply(x, 7);
            check("R6 wallace low bits", int'(p_w[2:0]), (x * 7) % 8);
            check("R6 wallace full", p_w, x * 7);
        end
        // R7: bit 0 bypasses the wide final adder
        for (int x = 1; x < 16; x += 2) begin
            apply(x, 11);
            check("R7 dadda bit0", int'(p_d[0]), (x * 11) % 2);
            check("R7 dadda full", p_d, x * 11);
        end

        // R8: long carry chains through the final adder
        apply(13, 11);
        check("R8 carry chain wallace", p_w, 143);
        check("R8 carry chain dadda", p_d, 143);
        apply(15, 9);
        check("R8 carry chain 15x9", p_d, 135);
        apply(7, 15);
        check("R8 carry chain 7x15", p_w, 105);

        // R9: one-hot operands
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                apply(1 << i, 1 << j);
                check("R9 onehot wallace", p_w, 1 << (i + j));
                check("R9 onehot dadda", p_d, 1 << (i + j));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule